// File: doc/BRIEF.md
# Low-power seconds counter with alarm

A memory-mapped real-time counter that keeps a 47-bit count. The count advances by one on every cycle where the slow tick-enable input is high, and that input pulses at 32.768 kHz. The bottom 15 bits are a sub-second fraction and the top 32 bits count whole seconds. A 32-bit register bus reads and writes the count, a seconds alarm value, a control word, a write-one-to-clear status word and a free 32-bit glitch-pattern word. A level interrupt output signals a pending alarm when the wakeup interrupt is enabled.

Control settings do not take effect at once. Each of the three control bits (run, alarm arm, wakeup) has a shadow copy. The shadow follows the written value after exactly three tick pulses, and only the shadows drive the counter and the alarm. The run bit reads back its shadow, so software can poll until the change has landed. The count can be loaded only while the shadowed run bit is low.

Software sets the time by stopping the counter and writing seconds shifted left by 15 into the two count words. It reads the time by sampling both words twice until the two samples agree.

Top module: `lp_rtc_top`

## Requirements
- R1: After reset every mapped register reads 0 and `irq` is 0.
- R2: Control bit 0 (run) reads back the shadowed run value. That value changes only on a tick, and it equals the written value from the third tick after the control write onward.
- R3: On a tick, while the shadowed run bit is 1, the 47-bit count increments by one. It holds when the shadowed run bit is 0 or when no tick arrives.
- R4: The low count word at 0x20 holds count bits 31:0. The high word at 0x1C holds bits 46:32 in its bits 14:0, with bits 31:15 reading 0. An increment from all ones wraps the count to 0.
- R5: Writes to either count word are ignored while the shadowed run bit is 1.
- R6: The alarm flag (status at 0x18, bit 0) is set on a tick where count bits 46:15 equal the alarm value at 0x24 while the shadowed arm bit (control bit 1) is 1. With the shadowed arm bit at 0, no tick sets it.
- R7: The alarm flag stays set until a status write with bit 0 = 1. A status write with bit 0 = 0 leaves it set.
- R8: `irq` equals the alarm flag AND the shadowed wakeup bit (control bit 3).
- R9: The glitch-pattern word at 0x30 stores and returns any 32-bit value, for example 0x41736166.
- R10: The alarm word at 0x24 stores and returns any 32-bit value.
- R11: Control bits 1 and 3 read back the last written value. All other control bits read 0, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Slow tick enable, one cycle per 32.768 kHz period |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on `bus_rdata` after the next edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, held between reads |
| irq | output | 1 | Level alarm interrupt |

## Verification
Several properties are checked on every cycle:
- the shadow bits move only on a tick;
- a running count steps by exactly one per tick and stays frozen between ticks even when a load is attempted;
- a stopped count changes only through a load;
- the alarm flag rises only on an armed, matching tick and stays set until it is cleared.

Other behaviour shows only in the bench's scenarios:
- the three-tick landing of a control write;
- the split of the count across the two words and its wrap from all ones;
- the exact tick on which the seconds field reaches the alarm value;
- the interrupt dropping three ticks after the wakeup bit is cleared while the flag stays set.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 47;
    localparam int FRAC_W     = 15;
    localparam int HI_W       = CNT_W - DATA_W;
    localparam int SEC_W      = CNT_W - FRAC_W;
    localparam int SYNC_DEPTH = 3;
    localparam int ADDR_W     = 8;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_CNT_HI = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_CNT_LO = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_ALARM  = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_GLITCH = 8'h30;

    localparam int BIT_RUN  = 0;
    localparam int BIT_ARM  = 1;
    localparam int BIT_WAKE = 3;

    typedef struct packed {
        logic wake;
        logic arm;
        logic run;
    } ctrl_t;

    localparam int CTRL_BITS = $bits(ctrl_t);

    function automatic logic [DATA_W-1:0] ctrl_word(input logic run_sh,
                                                    input logic arm,
                                                    input logic wake);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[BIT_RUN]  = run_sh;
        w[BIT_ARM]  = arm;
        w[BIT_WAKE] = wake;
        return w;
    endfunction
endpackage

// File: rtl/lp_rtc_ctrl_sync.sv
module lp_rtc_ctrl_sync #(
    parameter int NBITS = 3,
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [NBITS-1:0] req_i,
    output logic [NBITS-1:0] shadow_o
);
    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        logic [DEPTH-1:0] pipe_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe_q <= '0;
            end else if (tick_i) begin
                if (DEPTH > 1) begin
                    pipe_q <= {pipe_q[DEPTH-2:0], req_i[b]};
                end else begin
                    pipe_q <= req_i[b];
                end
            end
        end
        assign shadow_o[b] = pipe_q[DEPTH-1];

        p_shadow_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
            !tick_i |=> $stable(shadow_o[b]))
            else $error("shadow bit moved without a tick");
    end
endmodule

// File: rtl/lp_rtc_counter.sv
module lp_rtc_counter #(
    parameter int CNT_W = 47,
    parameter int LO_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_i,
    input  logic                  run_i,
    input  logic                  ld_lo_i,
    input  logic                  ld_hi_i,
    input  logic [LO_W-1:0]       lo_data_i,
    input  logic [CNT_W-LO_W-1:0] hi_data_i,
    output logic [CNT_W-1:0]      cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (run_i) begin
            if (tick_i) cnt_q <= cnt_q + 1'b1;
        end else begin
            if (ld_lo_i) cnt_q[LO_W-1:0]     <= lo_data_i;
            if (ld_hi_i) cnt_q[CNT_W-1:LO_W] <= hi_data_i;
        end
    end
    assign cnt_o = cnt_q;

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        run_i && tick_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1))
        else $error("running count did not step by one");

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !run_i && !ld_lo_i && !ld_hi_i |=> $stable(cnt_q))
        else $error("stopped count changed without a load");

    p_no_load_running_r5: assert property (@(posedge clk) disable iff (rst)
        run_i && !tick_i |=> $stable(cnt_q))
        else $error("running count changed between ticks");
endmodule

// File: rtl/lp_rtc_alarm.sv
module lp_rtc_alarm #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             arm_i,
    input  logic [SEC_W-1:0] secs_i,
    input  logic             wr_val_i,
    input  logic [SEC_W-1:0] wdata_i,
    input  logic             clr_i,
    output logic [SEC_W-1:0] alarm_o,
    output logic             flag_o
);
    logic [SEC_W-1:0] alarm_q;
    logic             flag_q;
    logic             hit;

    assign hit = tick_i && arm_i && (secs_i == alarm_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            if (wr_val_i) alarm_q <= wdata_i;
            if (hit)        flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
        end
    end
    assign alarm_o = alarm_q;
    assign flag_o  = flag_q;

    p_rise_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(tick_i && arm_i))
        else $error("alarm flag rose without an armed tick");

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        flag_q && !clr_i |=> flag_q)
        else $error("alarm flag dropped without a clear");
endmodule

// File: rtl/lp_rtc_top.sv
module lp_rtc_top
    import lp_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic wr_ctrl, wr_stat, wr_hi, wr_lo, wr_alarm, wr_glitch;
    assign wr_ctrl   = bus_wr && (bus_addr == OFF_CTRL);
    assign wr_stat   = bus_wr && (bus_addr == OFF_STAT);
    assign wr_hi     = bus_wr && (bus_addr == OFF_CNT_HI);
    assign wr_lo     = bus_wr && (bus_addr == OFF_CNT_LO);
    assign wr_alarm  = bus_wr && (bus_addr == OFF_ALARM);
    assign wr_glitch = bus_wr && (bus_addr == OFF_GLITCH);

    ctrl_t ctrl_q;
    ctrl_t ctrl_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.run  <= bus_wdata[BIT_RUN];
            ctrl_q.arm  <= bus_wdata[BIT_ARM];
            ctrl_q.wake <= bus_wdata[BIT_WAKE];
        end
    end

    lp_rtc_ctrl_sync #(.NBITS(CTRL_BITS), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_en),
        .req_i    (ctrl_q),
        .shadow_o (ctrl_sh)
    );

    logic [CNT_W-1:0] cnt;

    lp_rtc_counter #(.CNT_W(CNT_W), .LO_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_en),
        .run_i     (ctrl_sh.run),
        .ld_lo_i   (wr_lo),
        .ld_hi_i   (wr_hi),
        .lo_data_i (bus_wdata),
        .hi_data_i (bus_wdata[HI_W-1:0]),
        .cnt_o     (cnt)
    );

    logic [SEC_W-1:0] alarm_val;
    logic             flag;

    lp_rtc_alarm #(.SEC_W(SEC_W)) u_alarm (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_en),
        .arm_i    (ctrl_sh.arm),
        .secs_i   (cnt[CNT_W-1:FRAC_W]),
        .wr_val_i (wr_alarm),
        .wdata_i  (bus_wdata[SEC_W-1:0]),
        .clr_i    (wr_stat && bus_wdata[0]),
        .alarm_o  (alarm_val),
        .flag_o   (flag)
    );

    logic [DATA_W-1:0] glitch_q;
    always_ff @(posedge clk) begin
        if (rst)            glitch_q <= '0;
        else if (wr_glitch) glitch_q <= bus_wdata;
    end

    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        case (bus_addr)
            OFF_CTRL:   rd_mux = ctrl_word(ctrl_sh.run, ctrl_q.arm, ctrl_q.wake);
            OFF_STAT:   rd_mux = DATA_W'(flag);
            OFF_CNT_HI: rd_mux = DATA_W'(cnt[CNT_W-1:DATA_W]);
            OFF_CNT_LO: rd_mux = cnt[DATA_W-1:0];
            OFF_ALARM:  rd_mux = DATA_W'(alarm_val);
            OFF_GLITCH: rd_mux = glitch_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign irq = flag && ctrl_sh.wake;
endmodule

// File: tb/lp_rtc_top_tb_top.sv
`timescale 1ns/1ps
module lp_rtc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    lp_rtc_top dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam logic [7:0] A_CTRL = 8'h04, A_STAT = 8'h18, A_HI = 8'h1C,
                           A_LO = 8'h20, A_ALM = 8'h24, A_GL = 8'h30;

    // {addr, write data, expected read-back}
    localparam logic [71:0] VEC [8] = '{
        {A_GL,   32'h41736166, 32'h41736166},
        {A_ALM,  32'hDEADBEEF, 32'hDEADBEEF},
        {A_LO,   32'h12345678, 32'h12345678},
        {A_HI,   32'hFFFFFFFF, 32'h00007FFF},
        {A_CTRL, 32'hFFFFFFFF, 32'h0000000A},
        {A_CTRL, 32'h00000000, 32'h00000000},
        {8'h08,  32'h00000055, 32'h00000000},
        {A_STAT, 32'hFFFFFFFF, 32'h00000000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_STAT, v); check("R1 status", v, 0);
        rd(A_LO, v);   check("R1 cnt lo", v, 0);
        rd(A_HI, v);   check("R1 cnt hi", v, 0);
        rd(A_ALM, v);  check("R1 alarm", v, 0);
        rd(A_GL, v);   check("R1 glitch", v, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // register table: R9 R10 R4 R11
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            check($sformatf("R9_R10_R4_R11 vec%0d", i), v, VEC[i][31:0]);
        end

        // R2 three-tick landing, R3, R4 wrap
        wr(A_LO, 32'hFFFFFFFF);
        wr(A_HI, 32'h00007FFF);
        wr(A_CTRL, 32'h1);
        ticks(2);
        rd(A_CTRL, v); check("R2 run not yet landed", v, 0);
        ticks(1);
        rd(A_CTRL, v); check("R2 run landed", v, 1);
        rd(A_LO, v);   check("R3 no count on landing tick", v, 32'hFFFFFFFF);
        ticks(1);
        rd(A_LO, v);   check("R4 wrap lo", v, 0);
        rd(A_HI, v);   check("R4 wrap hi", v, 0);

        // R5 loads ignored while running
        wr(A_LO, 32'h00001234);
        wr(A_HI, 32'h00000055);
        rd(A_LO, v); check("R5 lo load ignored", v, 0);
        rd(A_HI, v); check("R5 hi load ignored", v, 0);
        ticks(2);
        rd(A_LO, v); check("R3 two steps", v, 2);

        // R3 stop: counts on the three sync ticks, then holds
        wr(A_CTRL, 32'h0);
        ticks(3);
        rd(A_CTRL, v); check("R2 run cleared", v, 0);
        ticks(1);
        rd(A_LO, v); check("R3 hold when stopped", v, 5);

        // R6 R8 alarm match on seconds 0x10
        wr(A_LO, 32'h0007FFFD);
        wr(A_HI, 32'h0);
        wr(A_ALM, 32'h10);
        wr(A_CTRL, 32'hB);
        ticks(6);
        rd(A_STAT, v); check("R6 no flag before match", v, 0);
        check("R8 irq low before match", {31'b0, irq}, 0);
        ticks(1);
        rd(A_STAT, v); check("R6 flag on match tick", v, 1);
        check("R8 irq high", {31'b0, irq}, 1);

        // R7 write zero keeps flag
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); check("R7 zero write keeps flag", v, 1);

        // R8 wake off: irq drops on third tick, flag stays
        wr(A_CTRL, 32'h1);
        ticks(2);
        check("R8 irq still high", {31'b0, irq}, 1);
        ticks(1);
        check("R8 irq low with wake off", {31'b0, irq}, 0);
        rd(A_STAT, v); check("R8 flag still set", v, 1);

        // R7 clear, R6 disarmed tick does not set
        wr(A_STAT, 32'h1);
        rd(A_STAT, v); check("R7 cleared", v, 0);
        ticks(1);
        rd(A_STAT, v); check("R6 disarmed no set", v, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule